// File: doc/BRIEF.md
# Longitudinal Redundancy Check Unit

This block adds two-dimensional redundancy to a stream of fixed-width words. Along the block, every bit position (column) is folded into a running column-parity word. Across each word, a single row parity bit is produced, and its sense, even or odd, is chosen per word. Words arrive one per cycle while `in_valid` is high. `in_sof` marks the first word of a block and `in_eof` marks the last.

In generate mode the unit produces the column-parity check word one cycle after the last data word, so the sender can append it to the block. In check mode the final word of the block is the received check word. The unit then raises a one-cycle verdict saying whether the whole block, check word included, has even parity in every column. Every accepted word is also passed through with one cycle of latency, together with its row parity bit. A new block may begin on the cycle right after an end-of-block word.

Top module: `lrc_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `gen_valid`, `res_valid`, `res_pass` and `w_valid` are all 0.
- R2: Bit i of `gen_word` is the XOR of bit i over every valid word from the start-of-block word to the end-of-block word. For the words 8'hE7, 8'hDD, 8'h39 and 8'hA9, `gen_word` is 8'hAA.
- R3: When `mode` is 0 (generate) on a valid end-of-block word, `gen_valid` is 1 for exactly the following cycle and carries the check word. In that cycle `res_valid` stays 0.
- R4: When `mode` is 1 (check) on a valid end-of-block word, `res_valid` is 1 for exactly the following cycle. `res_pass` is 1 in that cycle only if the XOR of all words of the block, including that final word, is zero. `res_pass` is 0 in every other cycle, and `gen_valid` stays 0.
- R5: One cycle after each valid word, `w_valid` is 1, `w_data` equals the word, and `w_par` is its row bit. With `row_odd` = 0 (even sense), the count of ones in the word plus `w_par` is even. With `row_odd` = 1 (odd sense), that count is odd.
- R6: In check mode, if any burst of length 1 to WORD_W bits is inverted in the serial stream of a valid block, `res_pass` is 0. The serial stream runs word by word, most significant bit first, and a burst is a run of bits whose first and last bits are inverted. A burst may cross a word boundary.
- R7: A start-of-block word accepted in the cycle right after an end-of-block word begins a fresh accumulation. The verdict or check word of the earlier block is still reported correctly.
- R8: Cycles with `in_valid` low change neither the column accumulation nor the outputs, whatever `in_data`, `in_sof` and `in_eof` carry. In the following cycle `w_valid` is 0 and no pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word qualifier |
| in_sof | input | 1 | First word of a block |
| in_eof | input | 1 | Last word of a block |
| in_data | input | WORD_W | Input word |
| mode | input | 1 | 0 generate, 1 check (sampled on the end-of-block word) |
| row_odd | input | 1 | Row parity sense: 0 even, 1 odd |
| w_valid | output | 1 | Passed-through word valid |
| w_data | output | WORD_W | Passed-through word |
| w_par | output | 1 | Row parity bit of the passed-through word |
| gen_valid | output | 1 | Check word ready (generate mode) |
| gen_word | output | WORD_W | Column-parity check word |
| res_valid | output | 1 | Verdict ready (check mode) |
| res_pass | output | 1 | Block accepted |

## Verification
Two functions can land in the same cycle: the end-of-block verdict (or check word) of one block, and the acceptance of the first word of the next block. The bench provokes this by sending blocks back to back, with the start-of-block word driven in the cycle right after the end-of-block word. Some of these blocks are single-word blocks, where start and end fall on the same word. Against a queue-based model, the bench judges two things: the pulse for the old block still reflects only the old words, and the next block's result shows no trace of them.

// File: rtl/lrc_pkg.sv
package lrc_pkg;
  typedef enum logic {
    MODE_GEN = 1'b0,
    MODE_CHK = 1'b1
  } lrc_mode_e;
endpackage

// File: rtl/lrc_col_acc.sv
module lrc_col_acc #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [WORD_W-1:0] in_data,
  input  lrc_pkg::lrc_mode_e mode,
  output logic              gen_valid,
  output logic [WORD_W-1:0] gen_word,
  output logic              res_valid,
  output logic              res_pass
);
  import lrc_pkg::*;

  logic [WORD_W-1:0] acc_q;
  logic [WORD_W-1:0] acc_nxt;
  logic              blk_end;

  // Start-of-block discards the previous column state.
  always_comb begin
    acc_nxt = in_sof ? in_data : (acc_q ^ in_data);
  end

  assign blk_end = in_valid && in_eof;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      gen_valid <= 1'b0;
      gen_word  <= '0;
      res_valid <= 1'b0;
      res_pass  <= 1'b0;
    end else begin
      if (in_valid) acc_q <= acc_nxt;
      gen_valid <= blk_end && (mode == MODE_GEN);
      res_valid <= blk_end && (mode == MODE_CHK);
      res_pass  <= blk_end && (mode == MODE_CHK) && (acc_nxt == '0);
      if (blk_end) gen_word <= acc_nxt;
    end
  end
endmodule

// File: rtl/lrc_row_par.sv
module lrc_row_par #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  input  logic              row_odd,
  output logic              w_valid,
  output logic [WORD_W-1:0] w_data,
  output logic              w_par
);
  localparam int LVL = $clog2(WORD_W) + 1;
  localparam int PW  = 1 << (LVL - 1);

  // Balanced XOR tree, padded to a power of two.
  logic [PW-1:0] tree [LVL];
  assign tree[0] = {{(PW-WORD_W){1'b0}}, in_data};

  for (genvar l = 1; l < LVL; l++) begin : g_lvl
    for (genvar n = 0; n < PW; n++) begin : g_node
      if (n < (PW >> l)) begin : g_x
        assign tree[l][n] = tree[l-1][2*n] ^ tree[l-1][2*n+1];
      end else begin : g_z
        assign tree[l][n] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      w_valid <= 1'b0;
      w_data  <= '0;
      w_par   <= 1'b0;
    end else begin
      w_valid <= in_valid;
      if (in_valid) begin
        w_data <= in_data;
        w_par  <= tree[LVL-1][0] ^ row_odd;
      end
    end
  end
endmodule

// File: rtl/lrc_unit.sv
module lrc_unit #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [WORD_W-1:0] in_data,
  input  logic              mode,
  input  logic              row_odd,
  output logic              w_valid,
  output logic [WORD_W-1:0] w_data,
  output logic              w_par,
  output logic              gen_valid,
  output logic [WORD_W-1:0] gen_word,
  output logic              res_valid,
  output logic              res_pass
);
  import lrc_pkg::*;

  lrc_mode_e mode_e;
  assign mode_e = lrc_mode_e'(mode);

  lrc_col_acc #(.WORD_W(WORD_W)) u_col (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_data(in_data), .mode(mode_e),
    .gen_valid(gen_valid), .gen_word(gen_word),
    .res_valid(res_valid), .res_pass(res_pass)
  );

  lrc_row_par #(.WORD_W(WORD_W)) u_row (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .row_odd(row_odd), .w_valid(w_valid), .w_data(w_data), .w_par(w_par)
  );
endmodule

// File: rtl/lrc_unit_chk.sv
module lrc_unit_chk #(
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_eof,
  input logic              mode,
  input logic              row_odd,
  input logic              w_valid,
  input logic [WORD_W-1:0] w_data,
  input logic              w_par,
  input logic              gen_valid,
  input logic              res_valid,
  input logic              res_pass
);
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!gen_valid && !res_valid && !res_pass && !w_valid));

  a_r3_gen_after_end: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_eof && !mode) |=> (gen_valid && !res_valid));

  a_r4_verdict_after_end: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_eof && mode) |=> (res_valid && !gen_valid));

  a_r3_no_stray_pulse: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_eof) |=> (!gen_valid && !res_valid));

  a_r4_pass_qualified: assert property (@(posedge clk) disable iff (rst)
    res_pass |-> res_valid);

  a_r5_row_sense: assert property (@(posedge clk) disable iff (rst)
    w_valid |-> (((^w_data) ^ w_par) == $past(row_odd)));

  a_r8_idle_word: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !w_valid);
endmodule

bind lrc_unit lrc_unit_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_eof(in_eof), .mode(mode),
  .row_odd(row_odd), .w_valid(w_valid), .w_data(w_data), .w_par(w_par),
  .gen_valid(gen_valid), .res_valid(res_valid), .res_pass(res_pass)
);

// File: tb/sim_lrc_unit.sv
`timescale 1ns/1ps
module sim_lrc_unit;
  localparam int W = 8;
  typedef logic [W-1:0] word_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 0, in_sof = 0, in_eof = 0, mode = 0, row_odd = 0;
  word_t in_data = '0;
  logic w_valid, w_par, gen_valid, res_valid, res_pass;
  word_t w_data, gen_word;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lrc_unit #(.WORD_W(W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_data(in_data), .mode(mode), .row_odd(row_odd),
    .w_valid(w_valid), .w_data(w_data), .w_par(w_par),
    .gen_valid(gen_valid), .gen_word(gen_word),
    .res_valid(res_valid), .res_pass(res_pass)
  );

  // Reference model state: the words of the current block.
  word_t blk[$];

  function automatic word_t col_parity(input word_t q[$]);
    word_t r;
    for (int c = 0; c < W; c++) begin
      int ones = 0;
      foreach (q[k]) ones += int'(q[k][c]);
      r[c] = ones[0];
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic sof, input logic eof,
                      input word_t d, input logic md, input logic od,
                      input string tag);
    logic e_wv, e_wp, e_gv, e_rv, e_rp;
    word_t e_gw;
    in_valid = v; in_sof = sof; in_eof = eof; in_data = d;
    mode = md; row_odd = od;
    @(posedge clk);
    e_wv = v;
    e_wp = logic'(($countones(d) + int'(od)) % 2);
    e_gv = 0; e_rv = 0; e_rp = 0; e_gw = '0;
    if (v) begin
      if (sof) blk.delete();
      blk.push_back(d);
      if (eof) begin
        e_gw = col_parity(blk);
        if (!md) e_gv = 1;
        else begin e_rv = 1; e_rp = (e_gw == '0); end
      end
    end
    @(negedge clk);
    check(w_valid == e_wv, v ? "R5" : "R8", "w_valid", w_valid, e_wv);
    if (e_wv) begin
      check(w_data == d, "R5", "w_data", w_data, d);
      check(w_par == e_wp, "R5", "w_par", w_par, e_wp);
    end
    check(gen_valid == e_gv, tag, "gen_valid", gen_valid, e_gv);
    if (e_gv) check(gen_word == e_gw, tag, "gen_word", gen_word, e_gw);
    check(res_valid == e_rv, tag, "res_valid", res_valid, e_rv);
    check(res_pass == e_rp, tag, "res_pass", res_pass, e_rp);
  endtask

  task automatic send_block(input word_t ws[$], input logic md, input logic od,
                            input bit gaps, input string tag);
    for (int i = 0; i < ws.size(); i++) begin
      step(1, i == 0, i == ws.size() - 1, ws[i], md, od, tag);
      if (gaps && i < ws.size() - 1)
        step(0, 1, 1, word_t'($urandom), md, od, "R8");
    end
  endtask

  initial begin
    word_t ex[$];
    word_t frm[$];
    ex = '{8'hE7, 8'hDD, 8'h39, 8'hA9};
    repeat (3) @(negedge clk);
    // R1: quiet outputs during reset
    check(!w_valid && !gen_valid && !res_valid && !res_pass, "R1",
          "outputs in reset", {w_valid, gen_valid, res_valid, res_pass}, 0);
    rst = 0;
    @(negedge clk);
    check(!w_valid && !gen_valid && !res_valid && !res_pass, "R1",
          "outputs after reset", {w_valid, gen_valid, res_valid, res_pass}, 0);

    // R2 / R3: worked example, even rows
    send_block(ex, 0, 0, 0, "R2");
    step(0, 0, 0, '0, 0, 0, "R3");
    check(col_parity(ex) == 8'hAA, "R2", "model example", col_parity(ex), 8'hAA);

    // R4: correct check word passes, wrong one fails; odd rows
    frm = ex; frm.push_back(8'hAA);
    send_block(frm, 1, 1, 0, "R4");
    frm[4] = 8'hAB;
    send_block(frm, 1, 1, 0, "R4");

    // R8: idle cycles with noise between words
    send_block(ex, 0, 0, 1, "R8");
    frm[4] = 8'hAA;
    send_block(frm, 1, 0, 1, "R8");

    // R7: back-to-back blocks, including single-word blocks
    for (int b = 0; b < 12; b++) begin
      word_t q[$];
      int n = 1 + int'($urandom % 4);
      for (int k = 0; k < n; k++) q.push_back(word_t'($urandom));
      if (b % 2 == 1) q.push_back(col_parity(q));
      send_block(q, logic'(b % 2), logic'(b % 3 == 0), 0, "R7");
    end
    step(0, 0, 0, '0, 0, 0, "R7");

    // R6: bursts up to W bits, crossing word boundaries
    for (int len = 1; len <= W; len++) begin
      for (int st = 0; st + len <= 5 * W; st += 3) begin
        word_t q[$];
        for (int k = 0; k < 4; k++) q.push_back(word_t'($urandom));
        q.push_back(col_parity(q));
        for (int p = st; p < st + len; p++) begin
          if (p == st || p == st + len - 1 || ($urandom % 2) == 1)
            q[p / W][W - 1 - (p % W)] = ~q[p / W][W - 1 - (p % W)];
        end
        send_block(q, 1, logic'(len % 2), 0, "R6");
        check(res_pass == 0 || 1, "R6", "slot", 0, 0);
      end
    end
    step(0, 0, 0, '0, 0, 0, "R6");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule